// File: doc/BRIEF.md
# Method Invocation Bus Proxy

This block stands in for a hardware object on the client's side of a shared bus. The client sees an object interface: one start strobe and one done strobe for each method, a parameter input port and a result output port. What happens behind that interface is a remote call. The proxy captures the parameter beats the client presents. It replays them as bus write transactions to the address assigned to that method. For a method that returns a value, it then issues one bus read. When the last transaction is acknowledged, it pulses the method's done line.

Each method is configured at elaboration time. The configuration gives its parameter beat count, whether it returns a value, and its address. The address is the target object's base address plus the method index times a fixed stride. The bus side is a simple master with one request outstanding. It holds request, write flag, address and write data until it samples an acknowledge. A client written against a locally attached object can therefore use the proxy without change.

Top module: `mip_proxy`

## Requirements
- R1: After reset, `bus_req_o` is low, every `done_o` bit is low and `result_o` is zero.
- R2: A call to method m ends with `done_o` equal to a one-cycle pulse on bit m only. `done_o` is never high on two bits, and never high in two consecutive cycles.
- R3: Beat k of a call's parameter (k = 0 in the cycle the start strobe is sampled, k = 1 in the next cycle, and so on) is taken from `param_i`. Each beat is written in ascending k order, one bus write per beat, with `bus_we_o` = 1. The beat count is fixed per method; by default methods 0..3 take 1, 0, 3 and 2 beats.
- R4: Every transaction of method m uses address BASE_ADDR + m * METHOD_STRIDE, which is 0x4000 + 0x10*m by default.
- R5: While `bus_req_o` is high and `bus_ack_i` is low, the request, `bus_we_o`, `bus_addr_o` and `bus_wdata_o` keep their values into the next cycle.
- R6: A method that returns a value issues exactly one read (`bus_we_o` = 0) after its writes. The returned value is `bus_rdata_i` as sampled in that read's acknowledge cycle, and it is on `result_o` in the done cycle. By default methods 1 and 2 return a value.
- R7: A method with no return value pulses done in the cycle right after the acknowledge of its last parameter write.
- R8: A start strobe that arrives while a call is in progress is ignored. This includes the call's done cycle. An ignored strobe causes no bus transaction and no done pulse.
- R9: When several start bits are high in one accepted cycle, the lowest-numbered method is called.
- R10: With n = beats + (1 if the method returns a value) and W wait cycles before each acknowledge, done rises n*(W+1)+1 cycles after the start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | NUM_M | Per-method start strobes |
| param_i | input | DW | Parameter beat from the client |
| done_o | output | NUM_M | Per-method completion pulses |
| result_o | output | DW | Returned value, valid in the done cycle |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | AW | Transaction address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Transaction acknowledge |
| bus_rdata_i | input | DW | Read data, valid with acknowledge |

## Verification
The bench numbers the cycles of a call from the cycle in which the start strobe is sampled. Because of the proxy's request register, the first request appears one cycle later. Each transaction then takes W+1 cycles, and the done register adds one more, so done is expected exactly n*(W+1)+1 cycles after the start. The bench's bus model acknowledges after a programmed W of 0, 1 or 2. It logs each transaction in its acknowledge cycle and compares the logged address, write flag and data with values derived from the method index and the beat formula. All outputs are sampled on the falling edge. Stray starts are injected one cycle after the start and in the expected done cycle. Observation runs six cycles past done, to show that no extra transaction or pulse follows.

// File: rtl/mip_pkg.sv
package mip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RD   = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_e;

  // address of a method inside the target object's window
  function automatic logic [31:0] method_address(logic [31:0] base, logic [31:0] stride,
                                                 logic [31:0] m);
    return base + stride * m;
  endfunction
endpackage

// File: rtl/mip_pick.sv
module mip_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/mip_beat_buf.sv
module mip_beat_buf #(
  parameter int DW = 8,
  parameter int MAX_BEATS = 4,
  localparam int BW = $clog2(MAX_BEATS + 1),
  localparam int IW = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [BW-1:0] lim_i,
  input  logic [DW-1:0] param_i,
  input  logic          fetch_i,
  input  logic [BW-1:0] idx_i,
  output logic [DW-1:0] data_o
);
  logic [DW-1:0] mem_q [MAX_BEATS];
  logic [BW-1:0] cap_cnt_q;
  logic [BW-1:0] cap_lim_q;
  logic          capturing;

  assign capturing = (cap_cnt_q < cap_lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_cnt_q <= '0;
      cap_lim_q <= '0;
      for (int i = 0; i < MAX_BEATS; i++) mem_q[i] <= '0;
    end else if (load_i) begin
      mem_q[0]  <= param_i;
      cap_cnt_q <= BW'(1);
      cap_lim_q <= lim_i;
    end else if (capturing) begin
      mem_q[cap_cnt_q[IW-1:0]] <= param_i;
      cap_cnt_q <= cap_cnt_q + BW'(1);
    end
  end

  // bypass: the beat being presented this very cycle
  always_comb begin
    if ((load_i && idx_i == '0) || (capturing && cap_cnt_q == idx_i))
      data_o = param_i;
    else
      data_o = mem_q[idx_i[IW-1:0]];
  end

  // R3
  beat_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_i && !load_i) |-> (idx_i <= cap_cnt_q));
endmodule

// File: rtl/mip_bus_seq.sv
module mip_bus_seq #(
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int MAX_BEATS = 4,
  parameter int NUM_M = 4,
  localparam int BW = $clog2(MAX_BEATS + 1),
  localparam int MIW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any_i,
  input  logic [MIW-1:0] idx_i,
  input  logic [BW-1:0]  beats_i,
  input  logic           ret_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  beat_data_i,
  output logic [BW-1:0]  beat_idx_o,
  output logic           load_first_o,
  output logic           fetch_o,
  output logic           fin_o,
  output logic [MIW-1:0] cur_o,
  output logic [DW-1:0]  result_o,
  output logic           bus_req_o,
  output logic           bus_we_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic           bus_ack_i,
  input  logic [DW-1:0]  bus_rdata_i
);
  import mip_pkg::*;

  seq_state_e    st_q;
  logic [BW-1:0] wcnt_q;
  logic [BW-1:0] nbeats_q;
  logic          ret_q;
  logic [BW-1:0] wnext;
  logic          more_beats;

  assign wnext        = wcnt_q + BW'(1);
  assign more_beats   = (wnext < nbeats_q);
  assign load_first_o = (st_q == ST_IDLE) && any_i;
  assign fetch_o      = (st_q == ST_WR) && bus_ack_i && more_beats;
  assign beat_idx_o   = (st_q == ST_IDLE) ? '0 : wnext;
  assign fin_o        = (st_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      wcnt_q      <= '0;
      nbeats_q    <= '0;
      ret_q       <= 1'b0;
      cur_o       <= '0;
      result_o    <= '0;
      bus_req_o   <= 1'b0;
      bus_we_o    <= 1'b0;
      bus_addr_o  <= '0;
      bus_wdata_o <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (any_i) begin
            cur_o      <= idx_i;
            nbeats_q   <= beats_i;
            ret_q      <= ret_i;
            bus_addr_o <= addr_i;
            wcnt_q     <= '0;
            if (beats_i != '0) begin
              st_q        <= ST_WR;
              bus_req_o   <= 1'b1;
              bus_we_o    <= 1'b1;
              bus_wdata_o <= beat_data_i;
            end else if (ret_i) begin
              st_q      <= ST_RD;
              bus_req_o <= 1'b1;
              bus_we_o  <= 1'b0;
            end else begin
              st_q <= ST_FIN;
            end
          end
        end
        ST_WR: begin
          if (bus_ack_i) begin
            if (more_beats) begin
              wcnt_q      <= wnext;
              bus_wdata_o <= beat_data_i;
            end else if (ret_q) begin
              st_q     <= ST_RD;
              bus_we_o <= 1'b0;
            end else begin
              st_q      <= ST_FIN;
              bus_req_o <= 1'b0;
            end
          end
        end
        ST_RD: begin
          if (bus_ack_i) begin
            result_o  <= bus_rdata_i;
            st_q      <= ST_FIN;
            bus_req_o <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
                                   $stable(bus_addr_o) && $stable(bus_wdata_o)));
  // R8
  req_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_o) |-> ($past(st_q) == ST_IDLE));
  // R7
  fin_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> ($past(bus_ack_i) || $past(st_q) == ST_IDLE));
  // R6
  result_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_o && ret_q) |-> (result_o == $past(bus_rdata_i)));
endmodule

// File: rtl/mip_proxy.sv
module mip_proxy #(
  parameter int NUM_M = 4,
  parameter int DW = 8,
  parameter int AW = 16,
  parameter int MAX_BEATS = 4,
  parameter logic [31:0] BASE_ADDR = 32'h0000_4000,
  parameter logic [31:0] METHOD_STRIDE = 32'h0000_0010,
  localparam int BW = $clog2(MAX_BEATS + 1),
  localparam int MIW = (NUM_M > 1) ? $clog2(NUM_M) : 1,
  parameter logic [NUM_M*BW-1:0] BEATS_VEC = {3'd2, 3'd3, 3'd0, 3'd1},
  parameter logic [NUM_M-1:0] RET_MASK = 4'b0110
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] start_i,
  input  logic [DW-1:0]    param_i,
  output logic [NUM_M-1:0] done_o,
  output logic [DW-1:0]    result_o,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic             bus_ack_i,
  input  logic [DW-1:0]    bus_rdata_i
);
  logic [NUM_M-1:0] grant;
  logic [MIW-1:0]   pick_idx;
  logic             pick_any;
  logic [AW-1:0]    maddr  [NUM_M];
  logic [BW-1:0]    mbeats [NUM_M];
  logic [BW-1:0]    beat_idx;
  logic [DW-1:0]    beat_data;
  logic             load_first;
  logic             fetch;
  logic             fin;
  logic [MIW-1:0]   cur;

  mip_pick #(.N(NUM_M)) pick_i (
    .req_i(start_i), .grant_o(grant), .idx_o(pick_idx), .any_o(pick_any)
  );

  for (genvar m = 0; m < NUM_M; m++) begin : g_meth
    assign maddr[m]  = AW'(mip_pkg::method_address(BASE_ADDR, METHOD_STRIDE, 32'(m)));
    assign mbeats[m] = BEATS_VEC[m*BW +: BW];
    assign done_o[m] = fin && (cur == MIW'(m));
  end

  mip_beat_buf #(.DW(DW), .MAX_BEATS(MAX_BEATS)) buf_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_first), .lim_i(mbeats[pick_idx]),
    .param_i(param_i), .fetch_i(fetch), .idx_i(beat_idx), .data_o(beat_data)
  );

  mip_bus_seq #(.DW(DW), .AW(AW), .MAX_BEATS(MAX_BEATS), .NUM_M(NUM_M)) seq_i (
    .clk(clk), .rst_n(rst_n), .any_i(pick_any), .idx_i(pick_idx),
    .beats_i(mbeats[pick_idx]), .ret_i(RET_MASK[pick_idx]), .addr_i(maddr[pick_idx]),
    .beat_data_i(beat_data), .beat_idx_o(beat_idx), .load_first_o(load_first),
    .fetch_o(fetch), .fin_o(fin), .cur_o(cur), .result_o(result_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i)
  );

  // R2
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_o));
  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |=> (done_o == '0));
  // R9
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_any |-> ($onehot(grant) && ((start_i & (grant - 1'b1)) == '0)));
  // R8
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o != '0) |-> !bus_req_o);
endmodule

// File: tb/mip_proxy_tb_top.sv
module mip_proxy_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] start_i = '0;
  logic [7:0] param_i = '0;
  logic [3:0] done_o;
  logic [7:0] result_o;
  logic       bus_req_o, bus_we_o;
  logic [15:0] bus_addr_o;
  logic [7:0] bus_wdata_o;
  logic       bus_ack_i = 1'b0;
  logic [7:0] bus_rdata_i = '0;

  mip_proxy dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .param_i(param_i),
    .done_o(done_o), .result_o(result_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i),
    .bus_rdata_i(bus_rdata_i)
  );

  always #4 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0, c0 = 0;
  int lat = 0, wait_cnt = 0, hold_err = 0, log_n = 0;
  int done_n = 0, done_rel = 0;
  logic [3:0]  done_vec;
  logic [7:0]  done_res, rd_seed = '0;
  logic [15:0] log_addr [16];
  logic        log_we   [16];
  logic [7:0]  log_data [16];
  logic [15:0] h_addr;
  logic        h_we;
  logic [7:0]  h_data;
  int beats_tab [4] = '{1, 0, 3, 2};
  int ret_tab   [4] = '{0, 1, 1, 0};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // bus slave model
  always @(negedge clk) begin
    if (bus_req_o) begin
      if (wait_cnt == 0) begin
        h_addr = bus_addr_o; h_we = bus_we_o; h_data = bus_wdata_o;
      end else if (h_addr != bus_addr_o || h_we != bus_we_o ||
                   (h_we && h_data != bus_wdata_o)) begin
        hold_err = hold_err + 1;
      end
      if (wait_cnt == lat) begin
        bus_ack_i = 1'b1;
        bus_rdata_i = bus_addr_o[7:0] ^ 8'h5A ^ rd_seed;
        if (log_n < 16) begin
          log_addr[log_n] = bus_addr_o; log_we[log_n] = bus_we_o;
          log_data[log_n] = bus_wdata_o;
        end
        log_n = log_n + 1;
        wait_cnt = 0;
      end else begin
        bus_ack_i = 1'b0;
        wait_cnt = wait_cnt + 1;
      end
    end else begin
      bus_ack_i = 1'b0;
      wait_cnt = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && done_o != '0) begin
      done_n = done_n + 1; done_vec = done_o; done_rel = cyc - c0; done_res = result_o;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bval(int m, int r, int seed);
    return 8'((seed * 37 + r * 11 + m * 3 + 5) & 255);
  endfunction

  task automatic run_call(input int m, input logic [3:0] mask, input int w, input bit stray);
    int nb, rt, n, expc, seed;
    logic [15:0] ea;
    seed = m * 3 + w + 1;
    nb = beats_tab[m]; rt = ret_tab[m]; n = nb + rt; expc = n * (w + 1) + 1;
    ea = 16'h4000 + 16'(m * 16);
    lat = w; log_n = 0; done_n = 0; hold_err = 0; rd_seed = 8'(m * 7 + w);
    for (int r = 0; r <= expc + 6; r++) begin
      @(negedge clk);
      if (r == 0) c0 = cyc;
      if (r == 0) start_i = mask;
      else if (stray && (r == 1 || r == expc)) start_i = 4'b1111;
      else start_i = '0;
      param_i = (r < nb) ? bval(m, r, seed) : 8'hEE;
    end
    @(negedge clk); start_i = '0;
    check(done_n == 1, "R8 one done per call", done_n, 1);
    check(done_vec == 4'(1 << m), "R2/R9 done line", int'(done_vec), 1 << m);
    check(done_rel == expc, rt ? "R10/R6 done cycle" : "R10/R7 done cycle", done_rel, expc);
    check(log_n == n, "R3/R8 transaction count", log_n, n);
    check(hold_err == 0, "R5 hold until ack", hold_err, 0);
    for (int i = 0; i < nb && i < log_n; i++) begin
      check(log_addr[i] == ea, "R4 write address", int'(log_addr[i]), int'(ea));
      check(log_we[i] && log_data[i] == bval(m, i, seed), "R3 write beat",
            int'(log_data[i]), int'(bval(m, i, seed)));
    end
    if (rt != 0 && log_n > nb) begin
      check(log_addr[nb] == ea, "R4 read address", int'(log_addr[nb]), int'(ea));
      check(!log_we[nb], "R6 read flag", int'(log_we[nb]), 0);
      check(done_res == (ea[7:0] ^ 8'h5A ^ rd_seed), "R6 result", int'(done_res),
            int'(ea[7:0] ^ 8'h5A ^ rd_seed));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_req_o, "R1 req after reset", int'(bus_req_o), 0);
    check(done_o == '0, "R1 done after reset", int'(done_o), 0);
    check(result_o == '0, "R1 result after reset", int'(result_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      for (int w = 0; w < 3; w++)
        run_call(m, 4'(1 << m), w, (w != 1));
    run_call(1, 4'b0110, 1, 1'b0);  // R9 lowest of two
    run_call(2, 4'b1100, 0, 1'b1);  // R9 lowest of two
    run_call(0, 4'b1111, 2, 1'b0);  // R9 all four
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule